// File: doc/BRIEF.md
# Aperture Address Translation Unit

This block maps an address that lands inside a graphics aperture window onto a physical memory address. It does so by reading one page-table entry from system memory. A request carries an aperture-space address. The block first decides whether that address lies within the configured window. If it does, the block works out where the matching table entry sits and issues one read on a simple request/response memory port. When the entry returns, it is decoded into a page frame number, a valid flag and a coherency hint. The block then answers with the physical address, or with an error.

Table entries are 4 or 8 bytes wide, chosen per request by a configuration input. The page frame number is put together from three separate fields of the entry. The upper field exists only in 8-byte entries. In 4-byte mode the memory port still returns 64 bits, and the block picks the half that holds the entry. Only one translation is in flight at a time. The request handshake stays closed from acceptance until the response has been taken.

Top module: `aperture_xlate`

## Requirements
- R1: `req_ready` is high only while the block is idle. It drops in the cycle after a request is accepted and stays low until the response handshake (`rsp_valid` and `rsp_ready`) completes, so at most one translation is outstanding.
- R2: A request whose address is not within [`cfg_base`, `cfg_base` + 2^`cfg_size_lg`) completes with `rsp_err_range` = 1, `rsp_err_inval` = 0, `rsp_paddr` = 0 and `rsp_coh` = 0, and issues no memory read.
- R3: For an in-range request, exactly one read is issued, at address `cfg_table` + (((`req_addr` - `cfg_base`) >> PAGE_SHIFT) << M). M is 2 when `cfg_wide` = 0 and 3 when `cfg_wide` = 1.
- R4: Every read address lies within [`cfg_table`, `cfg_table` + max(1, 2^(`cfg_size_lg` - PAGE_SHIFT)) × 2^(2 + `cfg_wide`)) and is aligned to the entry size.
- R5: In 4-byte mode the entry is bits 63:32 of `mrd_rdata` when bit 2 of the read address is 1, and bits 31:0 when it is 0.
- R6: Frame number bits 19:0 come from entry bits 31:12, and frame number bits 27:20 come from entry bits 11:4. Entry bits 3:2 have no effect. `rsp_paddr` = (frame number << PAGE_SHIFT) | the in-page offset of the request, truncated to PA_W bits.
- R7: In 8-byte mode, frame number bits 59:28 come from `mrd_rdata` bits 63:32, and the entry's low word is `mrd_rdata` bits 31:0. In 4-byte mode, frame number bits 59:28 are zero.
- R8: An entry with bit 0 clear gives `rsp_err_inval` = 1, `rsp_paddr` = 0, `rsp_coh` = 0 and `rsp_err_range` = 0.
- R9: For a valid entry, `rsp_coh` = entry bit 1 AND `cfg_coh_en`.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and all response fields hold their values.
- R11: During and right after reset, `req_ready` = 1, `mrd_valid` = 0 and `rsp_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | RA_W | Aperture-space address to translate |
| cfg_base | input | RA_W | Aperture window base, page aligned |
| cfg_size_lg | input | SLW | log2 of the aperture window size in bytes |
| cfg_table | input | PA_W | Physical start of the page table, 8-byte aligned |
| cfg_wide | input | 1 | 1 selects 8-byte entries, 0 selects 4-byte entries |
| cfg_coh_en | input | 1 | Coherency enable status, ANDed with the entry hint |
| mrd_valid | output | 1 | Memory read request |
| mrd_ready | input | 1 | Memory accepts the read request |
| mrd_addr | output | PA_W | Byte address of the table entry |
| mrd_rvalid | input | 1 | Read data returned (one cycle) |
| mrd_rdata | input | 64 | Read data, 8-byte aligned word |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | PA_W | Translated physical address |
| rsp_coh | output | 1 | Coherency attribute for the access |
| rsp_err_inval | output | 1 | Entry was not valid |
| rsp_err_range | output | 1 | Address outside the aperture window |

## Verification
The bench checks the window edges: the base, the last byte, one below the base and one past the end. A design with an off-by-one compare would either read a table entry for an address outside the window or reject the last page. It drives odd page indices in 4-byte mode, where the entry sits in the upper half of the returned word. A design that ignores address bit 2 would decode the neighbouring entry. In 8-byte mode it compares the high frame-number bits against the expected address, which catches a wrong shift by M or a missing upper field. It also holds the response stalled for a few cycles and feeds entries with the valid bit clear. A design that drops a held response or leaks a frame number through an invalid entry would produce a mismatch.

// File: rtl/aperture_xlate_pkg.sv
package aperture_xlate_pkg;

   typedef enum logic [1:0] {
      AX_IDLE  = 2'd0,
      AX_ISSUE = 2'd1,
      AX_WAIT  = 2'd2,
      AX_RESP  = 2'd3
   } ax_state_e;

   localparam int unsigned AX_LG_NARROW = 2;
   localparam int unsigned AX_LG_WIDE   = 3;
   localparam int unsigned AX_FRAME_MAX = 60;

   function automatic int unsigned ax_entry_lg(input logic wide);
      return wide ? AX_LG_WIDE : AX_LG_NARROW;
   endfunction

endpackage

// File: rtl/ax_window.sv
module ax_window #(
   parameter int unsigned RA_W       = 32,
   parameter int unsigned PAGE_SHIFT = 12,
   parameter int unsigned SLW        = 6,
   localparam int unsigned IDX_W     = RA_W - PAGE_SHIFT
) (
   input  logic [RA_W-1:0]       req_addr,
   input  logic [RA_W-1:0]       win_base,
   input  logic [SLW-1:0]        win_size_lg,
   output logic                  in_window,
   output logic [IDX_W-1:0]      page_idx,
   output logic [PAGE_SHIFT-1:0] page_off
);

   logic [RA_W:0]   span;
   logic [RA_W-1:0] delta;

   always_comb begin
      span      = {{RA_W{1'b0}}, 1'b1} << win_size_lg;
      delta     = req_addr - win_base;
      in_window = (req_addr >= win_base) && ({1'b0, delta} < span);
      page_idx  = delta[RA_W-1:PAGE_SHIFT];
      page_off  = delta[PAGE_SHIFT-1:0];
   end

endmodule

// File: rtl/ax_entry_addr.sv
module ax_entry_addr
   import aperture_xlate_pkg::*;
#(
   parameter int unsigned PA_W  = 44,
   parameter int unsigned IDX_W = 20
) (
   input  logic [PA_W-1:0]  tbl_base,
   input  logic [IDX_W-1:0] page_idx,
   input  logic             wide,
   output logic [PA_W-1:0]  entry_addr
);

   logic [PA_W-1:0] idx_ext;
   logic [PA_W-1:0] byte_off;

   always_comb begin
      idx_ext    = {{(PA_W-IDX_W){1'b0}}, page_idx};
      byte_off   = idx_ext << ax_entry_lg(wide);
      entry_addr = tbl_base + byte_off;
   end

endmodule

// File: rtl/ax_entry_decode.sv
module ax_entry_decode
   import aperture_xlate_pkg::*;
#(
   parameter int unsigned PA_W       = 44,
   parameter int unsigned PAGE_SHIFT = 12,
   localparam int unsigned FRAME_W   = PA_W - PAGE_SHIFT
) (
   input  logic [63:0]           rdata,
   input  logic                  upper_half,
   input  logic                  wide,
   input  logic                  coh_en,
   input  logic [PAGE_SHIFT-1:0] page_off,
   output logic                  ent_valid,
   output logic                  ent_coh,
   output logic [PA_W-1:0]       phys
);

   logic [31:0]             lo_word;
   logic [31:0]             hi_field;
   logic [AX_FRAME_MAX-1:0] frame_full;
   logic [FRAME_W-1:0]      frame;

   always_comb begin
      if (wide)            lo_word = rdata[31:0];
      else if (upper_half) lo_word = rdata[63:32];
      else                 lo_word = rdata[31:0];
      hi_field   = wide ? rdata[63:32] : 32'd0;
      frame_full = {hi_field, lo_word[11:4], lo_word[31:12]};
   end

   generate
      if (FRAME_W == AX_FRAME_MAX) begin : g_full_frame
         assign frame = frame_full;
         logic unused_rsv;
         assign unused_rsv = ^lo_word[3:2];
      end else begin : g_cut_frame
         assign frame = frame_full[FRAME_W-1:0];
         logic unused_rsv;
         assign unused_rsv = ^{frame_full[AX_FRAME_MAX-1:FRAME_W], lo_word[3:2]};
      end
   endgenerate

   always_comb begin
      ent_valid = lo_word[0];
      ent_coh   = ent_valid & lo_word[1] & coh_en;
      phys      = ent_valid ? {frame, page_off} : '0;
   end

endmodule

// File: rtl/aperture_xlate.sv
module aperture_xlate
   import aperture_xlate_pkg::*;
#(
   parameter int unsigned RA_W       = 32,
   parameter int unsigned PA_W       = 44,
   parameter int unsigned PAGE_SHIFT = 12,
   parameter int unsigned SLW        = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [RA_W-1:0] req_addr,
   input  logic [RA_W-1:0] cfg_base,
   input  logic [SLW-1:0]  cfg_size_lg,
   input  logic [PA_W-1:0] cfg_table,
   input  logic            cfg_wide,
   input  logic            cfg_coh_en,
   output logic            mrd_valid,
   input  logic            mrd_ready,
   output logic [PA_W-1:0] mrd_addr,
   input  logic            mrd_rvalid,
   input  logic [63:0]     mrd_rdata,
   output logic            rsp_valid,
   input  logic            rsp_ready,
   output logic [PA_W-1:0] rsp_paddr,
   output logic            rsp_coh,
   output logic            rsp_err_inval,
   output logic            rsp_err_range
);

   localparam int unsigned IDX_W = RA_W - PAGE_SHIFT;

   if (PAGE_SHIFT < 3 || PAGE_SHIFT >= RA_W) begin : g_bad_page
      $error("aperture_xlate: PAGE_SHIFT out of range");
   end
   if (PA_W < IDX_W + AX_LG_WIDE || PA_W < RA_W) begin : g_bad_pa
      $error("aperture_xlate: PA_W too small for the table index");
   end
   if (PA_W - PAGE_SHIFT > AX_FRAME_MAX) begin : g_bad_frame
      $error("aperture_xlate: PA_W exceeds the frame number reach");
   end
   if ((1 << SLW) <= RA_W) begin : g_bad_slw
      $error("aperture_xlate: SLW cannot encode a full window");
   end

   ax_state_e             state_q;
   logic                  hit;
   logic [IDX_W-1:0]      idx;
   logic [PAGE_SHIFT-1:0] off;
   logic [PA_W-1:0]       ent_addr;

   logic [PA_W-1:0]       ent_addr_q;
   logic [PAGE_SHIFT-1:0] off_q;
   logic                  wide_q;
   logic                  coh_en_q;

   logic                  dec_valid;
   logic                  dec_coh;
   logic [PA_W-1:0]       dec_phys;

   logic [PA_W-1:0]       paddr_q;
   logic                  coh_q;
   logic                  inval_q;
   logic                  range_q;

   ax_window #(
      .RA_W       (RA_W),
      .PAGE_SHIFT (PAGE_SHIFT),
      .SLW        (SLW)
   ) u_window (
      .req_addr    (req_addr),
      .win_base    (cfg_base),
      .win_size_lg (cfg_size_lg),
      .in_window   (hit),
      .page_idx    (idx),
      .page_off    (off)
   );

   ax_entry_addr #(
      .PA_W  (PA_W),
      .IDX_W (IDX_W)
   ) u_entry_addr (
      .tbl_base   (cfg_table),
      .page_idx   (idx),
      .wide       (cfg_wide),
      .entry_addr (ent_addr)
   );

   ax_entry_decode #(
      .PA_W       (PA_W),
      .PAGE_SHIFT (PAGE_SHIFT)
   ) u_decode (
      .rdata      (mrd_rdata),
      .upper_half (ent_addr_q[2]),
      .wide       (wide_q),
      .coh_en     (coh_en_q),
      .page_off   (off_q),
      .ent_valid  (dec_valid),
      .ent_coh    (dec_coh),
      .phys       (dec_phys)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= AX_IDLE;
         ent_addr_q <= '0;
         off_q      <= '0;
         wide_q     <= 1'b0;
         coh_en_q   <= 1'b0;
         paddr_q    <= '0;
         coh_q      <= 1'b0;
         inval_q    <= 1'b0;
         range_q    <= 1'b0;
      end else begin
         unique case (state_q)
            AX_IDLE: begin
               if (req_valid) begin
                  ent_addr_q <= ent_addr;
                  off_q      <= off;
                  wide_q     <= cfg_wide;
                  coh_en_q   <= cfg_coh_en;
                  if (hit) begin
                     state_q <= AX_ISSUE;
                  end else begin
                     paddr_q <= '0;
                     coh_q   <= 1'b0;
                     inval_q <= 1'b0;
                     range_q <= 1'b1;
                     state_q <= AX_RESP;
                  end
               end
            end
            AX_ISSUE: begin
               if (mrd_ready) state_q <= AX_WAIT;
            end
            AX_WAIT: begin
               if (mrd_rvalid) begin
                  paddr_q <= dec_phys;
                  coh_q   <= dec_coh;
                  inval_q <= ~dec_valid;
                  range_q <= 1'b0;
                  state_q <= AX_RESP;
               end
            end
            AX_RESP: begin
               if (rsp_ready) state_q <= AX_IDLE;
            end
            default: state_q <= AX_IDLE;
         endcase
      end
   end

   assign req_ready     = (state_q == AX_IDLE);
   assign mrd_valid     = (state_q == AX_ISSUE);
   assign mrd_addr      = ent_addr_q;
   assign rsp_valid     = (state_q == AX_RESP);
   assign rsp_paddr     = paddr_q;
   assign rsp_coh       = coh_q;
   assign rsp_err_inval = inval_q;
   assign rsp_err_range = range_q;

endmodule

// File: rtl/aperture_xlate_chk.sv
module aperture_xlate_chk #(
   parameter int unsigned PA_W       = 44,
   parameter int unsigned PAGE_SHIFT = 12,
   parameter int unsigned SLW        = 6
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic [SLW-1:0]  cfg_size_lg,
   input logic [PA_W-1:0] cfg_table,
   input logic            cfg_wide,
   input logic            mrd_valid,
   input logic [PA_W-1:0] mrd_addr,
   input logic            rsp_valid,
   input logic            rsp_ready,
   input logic [PA_W-1:0] rsp_paddr,
   input logic            rsp_coh,
   input logic            rsp_err_inval,
   input logic            rsp_err_range
);

   logic [PA_W-1:0] extent;
   logic [PA_W-1:0] rel;
   int unsigned     ent_lg;

   always_comb begin
      ent_lg = (int'(cfg_size_lg) >= int'(PAGE_SHIFT)) ? int'(cfg_size_lg) - PAGE_SHIFT : 0;
      extent = {{(PA_W-1){1'b0}}, 1'b1} << (ent_lg + 2 + (cfg_wide ? 1 : 0));
      rel    = mrd_addr - cfg_table;
   end

   // R1
   accept_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);

   // R1
   single_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({req_ready, mrd_valid, rsp_valid}));

   // R4
   read_extent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mrd_valid |-> (mrd_addr >= cfg_table) && (rel < extent)
                    && (mrd_addr[1:0] == 2'b00) && !(cfg_wide && mrd_addr[2]));

   // R10
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_coh)
                                  && $stable(rsp_err_inval) && $stable(rsp_err_range));

   // R8
   inval_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_err_inval |-> (rsp_paddr == '0) && !rsp_coh && !rsp_err_range);

   // R2
   range_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_err_range |-> (rsp_paddr == '0) && !rsp_coh && !rsp_err_inval);

   // R1
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_ready |=> req_ready);

endmodule

bind aperture_xlate aperture_xlate_chk #(
   .PA_W       (PA_W),
   .PAGE_SHIFT (PAGE_SHIFT),
   .SLW        (SLW)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .cfg_size_lg   (cfg_size_lg),
   .cfg_table     (cfg_table),
   .cfg_wide      (cfg_wide),
   .mrd_valid     (mrd_valid),
   .mrd_addr      (mrd_addr),
   .rsp_valid     (rsp_valid),
   .rsp_ready     (rsp_ready),
   .rsp_paddr     (rsp_paddr),
   .rsp_coh       (rsp_coh),
   .rsp_err_inval (rsp_err_inval),
   .rsp_err_range (rsp_err_range)
);

// File: tb/aperture_xlate_bench.sv
module aperture_xlate_bench;

   localparam int RA_W = 32;
   localparam int PA_W = 44;
   localparam int PS   = 12;
   localparam int SLW  = 6;

   logic            clk;
   logic            rst_n;
   logic            req_valid;
   logic            req_ready;
   logic [RA_W-1:0] req_addr;
   logic [RA_W-1:0] cfg_base;
   logic [SLW-1:0]  cfg_size_lg;
   logic [PA_W-1:0] cfg_table;
   logic            cfg_wide;
   logic            cfg_coh_en;
   logic            mrd_valid;
   logic            mrd_ready;
   logic [PA_W-1:0] mrd_addr;
   logic            mrd_rvalid;
   logic [63:0]     mrd_rdata;
   logic            rsp_valid;
   logic            rsp_ready;
   logic [PA_W-1:0] rsp_paddr;
   logic            rsp_coh;
   logic            rsp_err_inval;
   logic            rsp_err_range;

   aperture_xlate #(
      .RA_W (RA_W), .PA_W (PA_W), .PAGE_SHIFT (PS), .SLW (SLW)
   ) u_aperture_xlate (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
      .cfg_base (cfg_base), .cfg_size_lg (cfg_size_lg), .cfg_table (cfg_table),
      .cfg_wide (cfg_wide), .cfg_coh_en (cfg_coh_en),
      .mrd_valid (mrd_valid), .mrd_ready (mrd_ready), .mrd_addr (mrd_addr),
      .mrd_rvalid (mrd_rvalid), .mrd_rdata (mrd_rdata),
      .rsp_valid (rsp_valid), .rsp_ready (rsp_ready), .rsp_paddr (rsp_paddr),
      .rsp_coh (rsp_coh), .rsp_err_inval (rsp_err_inval), .rsp_err_range (rsp_err_range)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   int n_chk  = 0;
   int n_fail = 0;
   int n_reads = 0;
   bit done = 1'b0;
   logic [PA_W-1:0] last_rd = '0;
   bit   pend = 1'b0;
   int   lat  = 0;
   logic [PA_W-1:0] pend_addr = '0;

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   function automatic logic [63:0] mem_word(input logic [PA_W-1:0] a);
      logic [31:0] x;
      x = a[31:0] ^ {20'd0, a[PA_W-1:32]};
      return {(x * 32'h9E37_79B9) ^ 32'h5BD1_E995, (x * 32'h85EB_CA6B) ^ {x[15:0], x[31:16]}};
   endfunction

   // memory model: handshake sampled at the edge, data driven between edges
   always @(posedge clk) begin
      if (rst_n && mrd_valid && mrd_ready) begin
         pend      = 1'b1;
         pend_addr = mrd_addr;
         last_rd   = mrd_addr;
         lat       = int'($urandom % 3);
         n_reads++;
      end
   end

   always @(negedge clk) begin
      mrd_ready = ($urandom % 3) != 0;
      if (mrd_rvalid) begin
         mrd_rvalid = 1'b0;
      end else if (pend) begin
         if (lat == 0) begin
            mrd_rvalid = 1'b1;
            mrd_rdata  = mem_word({pend_addr[PA_W-1:3], 3'b000});
            pend       = 1'b0;
         end else begin
            lat--;
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      finish_run();
   end

   task automatic run_one(input logic [RA_W-1:0] addr);
      logic [RA_W:0]   span;
      logic [RA_W-1:0] delta;
      bit              hit;
      logic [PA_W-1:0] ea;
      logic [PA_W-1:0] ext;
      logic [63:0]     w;
      logic [31:0]     lo;
      logic [31:0]     hi;
      logic [59:0]     frame;
      logic [127:0]    full;
      logic [PA_W-1:0] exp_pa;
      bit              exp_coh;
      bit              exp_inv;
      logic [PA_W-1:0] h_pa;
      logic [3:0]      h_flags;
      int              r0;
      int              lg_ent;
      int              guard;
      string           tag;

      span  = {{RA_W{1'b0}}, 1'b1} << cfg_size_lg;
      delta = addr - cfg_base;
      hit   = (addr >= cfg_base) && ({1'b0, delta} < span);
      ea    = cfg_table + ({{(PA_W-RA_W+PS){1'b0}}, delta[RA_W-1:PS]} << (cfg_wide ? 3 : 2));
      lg_ent = (int'(cfg_size_lg) >= PS) ? int'(cfg_size_lg) - PS : 0;
      ext   = {{(PA_W-1){1'b0}}, 1'b1} << (lg_ent + 2 + (cfg_wide ? 1 : 0));
      w     = mem_word({ea[PA_W-1:3], 3'b000});
      lo    = cfg_wide ? w[31:0] : (ea[2] ? w[63:32] : w[31:0]);
      hi    = cfg_wide ? w[63:32] : 32'd0;
      frame = {hi, lo[11:4], lo[31:12]};
      full  = ({68'd0, frame} << PS) | {116'd0, addr[PS-1:0]};
      exp_inv = hit && !lo[0];
      exp_coh = hit && lo[0] && lo[1] && cfg_coh_en;
      exp_pa  = (hit && lo[0]) ? full[PA_W-1:0] : '0;
      tag = cfg_wide ? "R7" : (ea[2] ? "R5" : "R6");

      r0 = n_reads;
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = addr;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready, "R1", "ready after accept", {63'd0, req_ready}, 64'd0);
      guard = 0;
      while (!rsp_valid && guard < 200) begin
         @(negedge clk);
         guard++;
      end
      chk(rsp_valid, "R1", "response arrives", {63'd0, rsp_valid}, 64'd1);
      h_pa    = rsp_paddr;
      h_flags = {rsp_valid, rsp_coh, rsp_err_inval, rsp_err_range};
      repeat (int'($urandom % 3)) begin
         @(negedge clk);
         chk(rsp_paddr == h_pa && {rsp_valid, rsp_coh, rsp_err_inval, rsp_err_range} == h_flags,
             "R10", "held response", {20'd0, rsp_paddr}, {20'd0, h_pa});
      end
      chk(rsp_err_range == !hit, "R2", "range flag", {63'd0, rsp_err_range}, {63'd0, !hit});
      chk((n_reads - r0) == (hit ? 1 : 0), hit ? "R3" : "R2", "read count",
          64'(n_reads - r0), hit ? 64'd1 : 64'd0);
      if (hit) begin
         chk(last_rd == ea, "R3", "entry address", {20'd0, last_rd}, {20'd0, ea});
         chk((last_rd - cfg_table) < ext, "R4", "table extent",
             {20'd0, last_rd - cfg_table}, {20'd0, ext});
      end
      chk(rsp_err_inval == exp_inv, "R8", "invalid flag", {63'd0, rsp_err_inval}, {63'd0, exp_inv});
      chk(rsp_paddr == exp_pa, tag, "physical address", {20'd0, rsp_paddr}, {20'd0, exp_pa});
      chk(rsp_coh == exp_coh, "R9", "coherency", {63'd0, rsp_coh}, {63'd0, exp_coh});
      rsp_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rsp_ready = 1'b0;
      chk(req_ready, "R1", "ready after response", {63'd0, req_ready}, 64'd1);
   endtask

   task automatic set_cfg(input logic [RA_W-1:0] b, input int lg,
                          input logic [PA_W-1:0] t, input bit wd, input bit ce);
      @(negedge clk);
      cfg_base    = b;
      cfg_size_lg = SLW'(lg);
      cfg_table   = t;
      cfg_wide    = wd;
      cfg_coh_en  = ce;
   endtask

   initial begin
      void'($urandom(32'd4711));
      rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; rsp_ready = 1'b0;
      mrd_rvalid = 1'b0; mrd_rdata = '0; mrd_ready = 1'b0;
      cfg_base = 32'h4000_0000; cfg_size_lg = SLW'(16);
      cfg_table = 44'h123_4567_8000; cfg_wide = 1'b0; cfg_coh_en = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(req_ready && !mrd_valid && !rsp_valid, "R11", "in reset",
          {61'd0, req_ready, mrd_valid, rsp_valid}, 64'd4);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !mrd_valid && !rsp_valid, "R11", "after reset",
          {61'd0, req_ready, mrd_valid, rsp_valid}, 64'd4);

      for (int m = 0; m < 2; m++) begin
         set_cfg(32'h4000_0000, 16, 44'h123_4567_8000, m[0], 1'b1);
         run_one(32'h4000_0000);
         run_one(32'h4000_FFFF);
         run_one(32'h3FFF_FFFF);
         run_one(32'h4001_0000);
         run_one(32'h4000_1ABC);
         run_one(32'h4000_2123);
         run_one(32'h4000_3FFF);
      end
      set_cfg(32'h0000_0000, 32, 44'h800_0000_0008, 1'b0, 1'b0);
      run_one(32'hFFFF_FFFF);
      run_one(32'h0000_0000);
      set_cfg(32'h0000_5000, 10, 44'h000_0001_0000, 1'b1, 1'b1);
      run_one(32'h0000_5000);
      run_one(32'h0000_53FF);
      run_one(32'h0000_5400);

      for (int g = 0; g < 25; g++) begin
         int          lg;
         logic [31:0] b;
         logic [43:0] t;
         lg = 12 + int'($urandom % 17);
         b  = $urandom & ~((32'd1 << lg) - 32'd1);
         t  = {$urandom, $urandom} & 44'hFFF_FFFF_FFF8;
         set_cfg(b, lg, t, $urandom % 2 == 1, $urandom % 2 == 1);
         for (int k = 0; k < 12; k++) begin
            if ($urandom % 4 != 0)
               run_one(b + ($urandom & ((32'd1 << lg) - 32'd1)));
            else
               run_one($urandom);
         end
      end
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule